// File: doc/BRIEF.md
# Per-Pin Interrupt Sense Controller

This block turns a synchronized vector of general-purpose pin levels into interrupt requests. Every pin has a four-bit sense field. The low three bits select the event kind: rising edge, falling edge, high level, low level or either edge. The top bit chooses direct sampling of the incoming vector or one extra register stage before detection. Detected events are gated per pin by an accept mask and latched into a pending register. Software clears pending bits by writing ones to that register. Interrupt enables are changed through a pair of write-one strobe addresses, one that sets bits and one that clears them.

The masked status (pending AND enabled) drives two interrupt lines. One covers the lower half of the pins and the other covers the upper half. The accept mask lets software close a pin's detector while it rewrites that pin's sense field, so the change of mode cannot latch a false event. Register access uses a single-cycle write port and a combinational read port.

Top module: `pirq_sense_ctrl`

## Requirements
- R1: After reset, the accept mask, enables, pending bits and all sense fields read 0, and both interrupt lines are low.
- R2: The sense field of pin n is bits 4*(n mod 8)+3 down to 4*(n mod 8) of the sense register at address 8 + n/8. A written sense register reads back unchanged and controls only its own eight pins.
- R3: Sense code 0 (low three bits) latches pin n on a 0-to-1 change of the sampled level.
- R4: Sense code 1 latches on a 1-to-0 change of the sampled level.
- R5: Sense code 2 latches on every cycle the sampled level is 1, and code 3 latches on every cycle it is 0. The pending bit therefore comes back at once after a clear while the level stays active.
- R6: Sense code 4 latches on any change of the sampled level.
- R7: With field bit 3 set, an event is pending one clock edge after the pin changes. With bit 3 clear, it is pending two edges after. Codes 5 to 7 never latch.
- R8: While a pin's bit in the accept mask (address 0, read/write) is 0, no new event is latched for that pin.
- R9: Writing ones to address 1 sets those enable bits, and writing ones to address 2 clears them. Zeros leave bits unchanged. Both addresses read back the enable vector.
- R10: Writing a 1 to bit n of address 3 clears pin n's pending bit, and address 3 reads the pending vector. An event latched in the same cycle as the clear wins.
- R11: Address 4 reads pending AND enabled.
- R12: `irq_lo` is the OR of masked status bits 15:0, and `irq_hi` is the OR of bits 31:16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | NPINS | Synchronized pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq_lo | output | 1 | Interrupt for pins NPINS/2-1..0 |
| irq_hi | output | 1 | Interrupt for pins NPINS-1..NPINS/2 |

## Verification
A register write takes effect at the clock edge on which it is presented. An event on a direct-sampled pin is pending after the first edge that sees the new level, and an event on a delayed-sampled pin is pending one edge later. The interrupt lines and the read port follow the registers with no further delay. The bench drives every input one time unit after a rising edge. It updates its reference model at the same edge as the design and reads the registers and lines before the next edge, so each expected value is compared in the cycle it is due. The directed checks of the two-edge delay look at the pending bit both after the first edge and after the second.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
   localparam int unsigned DATA_W  = 32;
   localparam int unsigned FIELD_W = 4;
   localparam int unsigned ADDR_W  = 4;
   localparam int unsigned DIRECT_BIT = 3;

   localparam logic [ADDR_W-1:0] A_ACCEPT = 4'd0;
   localparam logic [ADDR_W-1:0] A_EN_SET = 4'd1;
   localparam logic [ADDR_W-1:0] A_EN_CLR = 4'd2;
   localparam logic [ADDR_W-1:0] A_PEND   = 4'd3;
   localparam logic [ADDR_W-1:0] A_MSTAT  = 4'd4;
   localparam logic [ADDR_W-1:0] A_SENSE0 = 4'd8;

   typedef enum logic [2:0] {
      K_RISE = 3'd0,
      K_FALL = 3'd1,
      K_HIGH = 3'd2,
      K_LOW  = 3'd3,
      K_ANY  = 3'd4
   } sense_kind_e;

   function automatic logic sense_hit(input logic [2:0] kind,
                                      input logic now_v,
                                      input logic old_v);
      logic r;
      case (kind)
         K_RISE:  r = now_v & ~old_v;
         K_FALL:  r = ~now_v & old_v;
         K_HIGH:  r = now_v;
         K_LOW:   r = ~now_v;
         K_ANY:   r = now_v ^ old_v;
         default: r = 1'b0;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/pirq_sense_bank.sv
module pirq_sense_bank
   import pirq_pkg::*;
#(
   parameter int unsigned NPINS = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [ADDR_W-1:0]              wr_addr,
   input  logic [DATA_W-1:0]              wr_data,
   output logic [NPINS/8-1:0][DATA_W-1:0] regs_q,
   output logic [NPINS*FIELD_W-1:0]       fields
);
   localparam int unsigned NREGS = NPINS / 8;

   for (genvar k = 0; k < NREGS; k++) begin : g_reg
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(A_SENSE0) + k);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs_q[k] <= '0;
         else if (wr_en && wr_addr == MY_ADDR)
            regs_q[k] <= wr_data;
      end
   end

   assign fields = regs_q;
endmodule

// File: rtl/pirq_pin_detect.sv
module pirq_pin_detect
   import pirq_pkg::*;
(
   input  logic [FIELD_W-1:0] field,
   input  logic               pin_now,
   input  logic               pin_d1,
   input  logic               pin_d2,
   input  logic               accept,
   output logic               event_o
);
   logic cur_v, old_v;

   always_comb begin
      if (field[DIRECT_BIT]) begin
         cur_v = pin_now;
         old_v = pin_d1;
      end else begin
         cur_v = pin_d1;
         old_v = pin_d2;
      end
      event_o = accept & sense_hit(field[2:0], cur_v, old_v);
   end
endmodule

// File: rtl/pirq_latch.sv
module pirq_latch
   import pirq_pkg::*;
#(
   parameter int unsigned NPINS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [NPINS-1:0]  wr_bits,
   input  logic [NPINS-1:0]  events,
   output logic [NPINS-1:0]  accept_q,
   output logic [NPINS-1:0]  en_q,
   output logic [NPINS-1:0]  pend_q,
   output logic [NPINS-1:0]  mstat
);
   logic [NPINS-1:0] clr_bits;

   assign clr_bits = (wr_en && wr_addr == A_PEND) ? wr_bits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         accept_q <= '0;
      else if (wr_en && wr_addr == A_ACCEPT)
         accept_q <= wr_bits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= '0;
      else if (wr_en && wr_addr == A_EN_SET)
         en_q <= en_q | wr_bits;
      else if (wr_en && wr_addr == A_EN_CLR)
         en_q <= en_q & ~wr_bits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= '0;
      else
         pend_q <= (pend_q & ~clr_bits) | events;
   end

   assign mstat = pend_q & en_q;
endmodule

// File: rtl/pirq_irq_merge.sv
module pirq_irq_merge #(
   parameter int unsigned NPINS   = 32,
   parameter int unsigned NGROUPS = 2
) (
   input  logic [NPINS-1:0]   mstat,
   output logic [NGROUPS-1:0] irq
);
   localparam int unsigned GSIZE = NPINS / NGROUPS;

   for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
      assign irq[g] = |mstat[g*GSIZE +: GSIZE];
   end
endmodule

// File: rtl/pirq_sense_ctrl.sv
module pirq_sense_ctrl
   import pirq_pkg::*;
#(
   parameter int unsigned NPINS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPINS-1:0]  pins_i,
   input  logic              wr_en,
   input  logic [3:0]        wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [3:0]        rd_addr,
   output logic [31:0]       rd_data,
   output logic              irq_lo,
   output logic              irq_hi
);
   localparam int unsigned NREGS   = NPINS / 8;
   localparam int unsigned NGROUPS = 2;

   if (NPINS % 16 != 0 || NPINS > DATA_W || NPINS == 0) begin : g_bad_npins
      $error("pirq_sense_ctrl: NPINS must be 16 or 32");
   end

   logic [NPINS-1:0]              pin_d1, pin_d2;
   logic [NREGS-1:0][DATA_W-1:0]  sense_regs;
   logic [NPINS*FIELD_W-1:0]      sense_fields;
   logic [NPINS-1:0]              events;
   logic [NPINS-1:0]              accept_q, en_q, pend_q, mstat;
   logic [NGROUPS-1:0]            irq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_d1 <= '0;
         pin_d2 <= '0;
      end else begin
         pin_d1 <= pins_i;
         pin_d2 <= pin_d1;
      end
   end

   pirq_sense_bank #(.NPINS(NPINS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .regs_q  (sense_regs),
      .fields  (sense_fields)
   );

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      pirq_pin_detect u_det (
         .field   (sense_fields[i*FIELD_W +: FIELD_W]),
         .pin_now (pins_i[i]),
         .pin_d1  (pin_d1[i]),
         .pin_d2  (pin_d2[i]),
         .accept  (accept_q[i]),
         .event_o (events[i])
      );
   end

   pirq_latch #(.NPINS(NPINS)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_bits  (wr_data[NPINS-1:0]),
      .events   (events),
      .accept_q (accept_q),
      .en_q     (en_q),
      .pend_q   (pend_q),
      .mstat    (mstat)
   );

   pirq_irq_merge #(.NPINS(NPINS), .NGROUPS(NGROUPS)) u_merge (
      .mstat (mstat),
      .irq   (irq)
   );

   assign irq_lo = irq[0];
   assign irq_hi = irq[1];

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_ACCEPT:           rd_data = DATA_W'(accept_q);
         A_EN_SET, A_EN_CLR: rd_data = DATA_W'(en_q);
         A_PEND:             rd_data = DATA_W'(pend_q);
         A_MSTAT:            rd_data = DATA_W'(mstat);
         default: begin
            for (int k = 0; k < int'(NREGS); k++) begin
               if (rd_addr == ADDR_W'(int'(A_SENSE0) + k))
                  rd_data = sense_regs[k];
            end
         end
      endcase
   end
endmodule

// File: rtl/pirq_sense_ctrl_chk.sv
module pirq_sense_ctrl_chk
   import pirq_pkg::*;
#(
   parameter int unsigned NPINS = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [3:0]       wr_addr,
   input logic [31:0]      wr_data,
   input logic             irq_lo,
   input logic             irq_hi,
   input logic [NPINS-1:0] pend,
   input logic [NPINS-1:0] en,
   input logic [NPINS-1:0] accept
);
   localparam int unsigned HALF = NPINS / 2;

   // R1: state is clear on the first edge after reset release
   assert_reset_clear_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (pend == '0 && en == '0 && accept == '0));

   // R8: a newly pending bit needs the accept bit in the cycle before
   assert_gate_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend & ~$past(pend) & ~$past(accept)) == '0));

   // R9: set strobe turns bits on, clear strobe turns bits off
   assert_en_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_EN_SET) |=>
      ((en & $past(wr_data[NPINS-1:0])) == $past(wr_data[NPINS-1:0])));

   assert_en_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_EN_CLR) |=> ((en & $past(wr_data[NPINS-1:0])) == '0));

   // R10: a cleared bit stays clear unless its detector was open
   assert_pend_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_PEND) |=>
      ((pend & $past(wr_data[NPINS-1:0]) & ~$past(accept)) == '0));

   // R12: each line follows its half of the masked status
   assert_irq_lo_R12: assert property (@(posedge clk) disable iff (!rst_n)
      irq_lo == |(pend[HALF-1:0] & en[HALF-1:0]));

   assert_irq_hi_R12: assert property (@(posedge clk) disable iff (!rst_n)
      irq_hi == |(pend[NPINS-1:HALF] & en[NPINS-1:HALF]));
endmodule

bind pirq_sense_ctrl pirq_sense_ctrl_chk #(.NPINS(NPINS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .irq_lo  (irq_lo),
   .irq_hi  (irq_hi),
   .pend    (pend_q),
   .en      (en_q),
   .accept  (accept_q)
);

// File: tb/pirq_sense_ctrl_bench.sv
module pirq_sense_ctrl_bench;
   localparam int NP = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pins = '0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        irq_lo, irq_hi;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [31:0] m_d1 = '0, m_d2 = '0, m_pend = '0, m_en = '0, m_acc = '0;
   logic [31:0] m_sense [4] = '{default: '0};

   always #5 clk = ~clk;

   pirq_sense_ctrl #(.NPINS(NP)) u_pirq_sense_ctrl (
      .clk(clk), .rst_n(rst_n), .pins_i(pins), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .irq_lo(irq_lo), .irq_hi(irq_hi)
   );

   function automatic logic ref_hit(input logic [3:0] f, input logic c, input logic p);
      case (f[2:0])
         3'd0: return c & ~p;
         3'd1: return ~c & p;
         3'd2: return c;
         3'd3: return ~c;
         3'd4: return c ^ p;
         default: return 1'b0;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one clock edge for both design and model
   task automatic step();
      logic [31:0] ev, clr, np, ne, na;
      logic [31:0] ns [4];
      ev = '0;
      for (int i = 0; i < NP; i++) begin
         logic [3:0] f;
         logic c, p;
         f = m_sense[i/8][(i%8)*4 +: 4];
         c = f[3] ? pins[i] : m_d1[i];
         p = f[3] ? m_d1[i] : m_d2[i];
         ev[i] = m_acc[i] & ref_hit(f, c, p);
      end
      clr = (wr_en && wr_addr == 4'd3) ? wr_data : '0;
      np = (m_pend & ~clr) | ev;
      ne = m_en;
      na = m_acc;
      ns = m_sense;
      if (wr_en) begin
         case (wr_addr)
            4'd0: na = wr_data;
            4'd1: ne = m_en | wr_data;
            4'd2: ne = m_en & ~wr_data;
            4'd8, 4'd9, 4'd10, 4'd11: ns[wr_addr - 4'd8] = wr_data;
            default: ;
         endcase
      end
      @(posedge clk);
      #1;
      m_pend = np; m_en = ne; m_acc = na; m_sense = ns;
      m_d2 = m_d1; m_d1 = pins;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic cmp_all();
      logic [31:0] v;
      rd(4'd0, v); chk("R8 accept readback", v, m_acc);
      rd(4'd1, v); chk("R9 enable readback", v, m_en);
      rd(4'd3, v); chk("R10 pending", v, m_pend);
      rd(4'd4, v); chk("R11 masked status", v, m_pend & m_en);
      chk("R12 irq_lo", {31'd0, irq_lo}, {31'd0, |(m_pend[15:0] & m_en[15:0])});
      chk("R12 irq_hi", {31'd0, irq_hi}, {31'd0, |(m_pend[31:16] & m_en[31:16])});
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;

      // R1 reset state
      cmp_all();
      for (int a = 8; a < 12; a++) begin
         rd(4'(a), v); chk("R1 sense reset", v, 32'h0);
      end
      chk("R1 irq lines", {30'd0, irq_hi, irq_lo}, 32'h0);

      // R2 field placement: pin 9 -> reg 9, bits 7:4
      wr(4'd9, 32'h0000_00A0);
      rd(4'd9, v); chk("R2 readback", v, 32'h0000_00A0);
      wr(4'd0, 32'h0000_0200);
      pins[9] = 1'b1;
      step();
      rd(4'd3, v); chk("R2 only pin 9 latched", v, 32'h0000_0200);
      pins[9] = 1'b0;
      wr(4'd3, 32'hFFFF_FFFF);
      rd(4'd3, v); chk("R10 clear", v, 32'h0);
      wr(4'd9, 32'h0);

      // pins 7..0: 8,C,D,0,B,A,9,8 ; pin 17: C
      wr(4'd8, 32'h8CD0_BA98);
      wr(4'd10, 32'h0000_00C0);
      wr(4'd0, 32'hFFFF_FFFF);
      wr(4'd1, 32'hFFFF_FFFF);
      rd(4'd3, v); chk("R5 low level latched", v, 32'h8);
      chk("R12 irq_lo on", {31'd0, irq_lo}, 32'h1);
      wr(4'd3, 32'h8);
      rd(4'd3, v); chk("R5 R10 level re-latches over clear", v, 32'h8);
      pins[3] = 1'b1;
      wr(4'd3, 32'h8);
      rd(4'd3, v); chk("R10 clear after level gone", v, 32'h0);

      pins[0] = 1'b1; pins[4] = 1'b1;
      step();
      rd(4'd3, v); chk("R3 rising direct, R7 delayed not yet", v, 32'h1);
      step();
      rd(4'd3, v); chk("R7 delayed rising after second edge", v, 32'h11);
      wr(4'd3, 32'hFFFF_FFFF);
      cmp_all();

      pins[1] = 1'b1; step();
      rd(4'd3, v); chk("R4 no event on rise", v, 32'h0);
      pins[1] = 1'b0; step();
      rd(4'd3, v); chk("R4 falling", v, 32'h2);
      pins[5] = 1'b1; step(); step();
      pins[5] = 1'b0; step(); step();
      rd(4'd3, v); chk("R7 code 5 ignored", v, 32'h2);
      wr(4'd3, 32'hFFFF_FFFF);

      pins[17] = 1'b1; step();
      rd(4'd3, v); chk("R6 both edges rise", v, 32'h0002_0000);
      chk("R12 hi/lo split", {30'd0, irq_hi, irq_lo}, 32'h2);
      wr(4'd3, 32'h0002_0000);
      pins[17] = 1'b0; step();
      rd(4'd3, v); chk("R6 both edges fall", v, 32'h0002_0000);
      wr(4'd2, 32'h0002_0000);
      rd(4'd4, v); chk("R11 masked off", v, 32'h0);
      rd(4'd1, v); chk("R9 enable clear", v, 32'hFFFD_FFFF);
      chk("R12 irq_hi off", {31'd0, irq_hi}, 32'h0);

      wr(4'd0, 32'hFFFF_FFFE);
      pins[0] = 1'b0; step();
      pins[0] = 1'b1; step();
      rd(4'd3, v); chk("R8 gated pin not latched", v, 32'h0002_0000);
      cmp_all();

      // random phase against the model
      for (int n = 0; n < 3000; n++) begin
         pins = pins ^ ($urandom & $urandom & $urandom);
         if ($urandom_range(3) == 0) begin
            logic [3:0] a;
            int s;
            s = $urandom_range(9);
            a = (s < 4) ? 4'(s) : (s < 6) ? 4'd3 : 4'(8 + s - 6);
            wr_en = 1'b1; wr_addr = a; wr_data = $urandom;
            if (a == 4'd3) wr_data = wr_data & $urandom;
         end
         step();
         wr_en = 1'b0;
         cmp_all();
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule